// File: doc/BRIEF.md
# Two-Way Latch/Register Bus Transceiver

This block moves an 18-bit word between an A bus and a B bus, with a separate path for each direction. Every path has three control lines of its own: an active-low output enable, a latch enable and a data clock. Each bit of a path holds one storage element. While the latch enable is high the element is transparent. While it is low, the element loads on a rising edge of the path clock and otherwise keeps its value. The same path can therefore act as a wire, a latch or a register. The word is built from two 9-bit lanes, so it can serve as two narrow transceivers or as one wide one.

Every input is sampled on a fast system clock, and a path-clock edge is recognised when one sample is low and the next is high. Output data and output drive-enable are separate ports. The pad that turns a deasserted drive into high impedance lies outside the block. A test override port lets an external boundary-test block take over the output values and drive-enables. While the override is active, the paths keep sampling and storing.

Top module: `bus_xcvr_top`

## Requirements
- R1: While the sampled latch enable of a path is 1, that path's output shows the input data taken at the latest system clock edge.
- R2: When the sampled latch enable of a path goes from 1 to 0, the output keeps the data sampled at the last edge at which the enable was still 1.
- R3: While the sampled latch enable is 0 and no path-clock rise is seen, the stored value and the output stay unchanged, whatever the input data does.
- R4: While the latch enable is 0, a path-clock rise (one sample 0, the next sample 1) stores the data sampled at the same edge as the 1. The stored data shows at the output one system clock later.
- R5: The drive output of a path is 1 exactly when its active-low output enable was 0 at the latest system clock edge.
- R6: The B-to-A path (inputs from B, outputs to A) follows R1 to R5 with its own three controls, and it is independent of the A-to-B path.
- R7: While the test select input is 1, both data outputs and both drive outputs equal the forced values on the override port, with no clock delay.
- R8: Paths keep sampling and storing while the test select is 1. After it returns to 0, the outputs show the state that normal operation would have reached.
- R9: During reset all data outputs are 0 and both drives are 0. A path clock that is already high when reset is released is not taken as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_in | input | 18 | A-bus input data |
| b_in | input | 18 | B-bus input data |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable |
| ab_ck | input | 1 | A-to-B data clock |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable |
| ba_ck | input | 1 | B-to-A data clock |
| tst_sel | input | 1 | Test override select |
| tst_b_data | input | 18 | Forced B-side output data |
| tst_a_data | input | 18 | Forced A-side output data |
| tst_b_drive | input | 1 | Forced B-side drive enable |
| tst_a_drive | input | 1 | Forced A-side drive enable |
| b_out | output | 18 | B-side output data |
| b_drive | output | 1 | B-side drive enable |
| a_out | output | 18 | A-side output data |
| a_drive | output | 1 | A-side drive enable |

## Verification
A corrupted storage element does not show up while its path is transparent. It appears at the output in the first cycle after the latch enable is sampled low, and it stays there until a path-clock rise reloads the element. A false or missed edge detection shows one system clock after the clock sample. So the stimulus keeps the latch enable low for long stretches and toggles the path clock slowly, which makes every held value visible for many cycles. It also drives a clock held high across reset and a capture made under test override, whose result can only be seen after the override is released.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
  localparam int unsigned LANE_W_DEF = 9;
  localparam int unsigned LANES_DEF  = 2;

  typedef struct packed {
    logic oe_n;
    logic le;
    logic ck;
  } path_ctl_t;
endpackage

// File: rtl/bus_xcvr_rst_sync.sv
module bus_xcvr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_nxt;
    end
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/bus_xcvr_sampler.sv
module bus_xcvr_sampler
  import bus_xcvr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  path_ctl_t    ctl_in,
  input  logic [W-1:0] d_in,
  output logic         le_s,
  output logic         oe_n_s,
  output logic [W-1:0] d_s,
  output logic         cap
);
  logic ck_s, ck_prev, primed;
  logic le_nxt, oe_nxt, ck_nxt, prev_nxt;
  logic [W-1:0] d_nxt;

  always_comb begin
    le_nxt   = ctl_in.le;
    oe_nxt   = ctl_in.oe_n;
    ck_nxt   = ctl_in.ck;
    d_nxt    = d_in;
    prev_nxt = primed ? ck_s : ctl_in.ck;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      le_s    <= 1'b0;
      oe_n_s  <= 1'b1;
      ck_s    <= 1'b0;
      ck_prev <= 1'b0;
      d_s     <= '0;
      primed  <= 1'b0;
    end else begin
      le_s    <= le_nxt;
      oe_n_s  <= oe_nxt;
      ck_s    <= ck_nxt;
      ck_prev <= prev_nxt;
      d_s     <= d_nxt;
      primed  <= 1'b1;
    end
  end

  assign cap = primed & ck_s & ~ck_prev;

  assert_cap_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> !cap)
    else $error("capture pulse longer than one cycle");
endmodule

// File: rtl/bus_xcvr_lane.sv
module bus_xcvr_lane #(
  parameter int unsigned LW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          le,
  input  logic          cap,
  input  logic [LW-1:0] d,
  output logic [LW-1:0] q_out
);
  logic [LW-1:0] store_q, store_nxt;
  logic          load_en;

  always_comb begin
    load_en   = le | cap;
    store_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
    end else if (load_en) begin
      store_q <= store_nxt;
    end
  end

  assign q_out = le ? d : store_q;

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && !cap) |=> $stable(store_q))
    else $error("stored value moved without enable or edge");

  assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && cap) |=> (store_q == $past(d)))
    else $error("edge did not capture sampled data");

  assert_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(le) |-> (q_out == $past(d)))
    else $error("latch close lost last transparent value");
endmodule

// File: rtl/bus_xcvr_path.sv
module bus_xcvr_path
  import bus_xcvr_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  path_ctl_t             ctl_in,
  input  logic [LANES*LANE_W-1:0] d_in,
  output logic [LANES*LANE_W-1:0] d_out,
  output logic                  drive
);
  localparam int unsigned W = LANES * LANE_W;

  logic         le_s, oe_n_s, cap;
  logic [W-1:0] d_s;

  bus_xcvr_sampler #(.W(W)) u_smp (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl_in (ctl_in),
    .d_in   (d_in),
    .le_s   (le_s),
    .oe_n_s (oe_n_s),
    .d_s    (d_s),
    .cap    (cap)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bus_xcvr_lane #(.LW(LANE_W)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .le    (le_s),
      .cap   (cap),
      .d     (d_s[g*LANE_W +: LANE_W]),
      .q_out (d_out[g*LANE_W +: LANE_W])
    );
  end

  assign drive = ~oe_n_s;
endmodule

// File: rtl/bus_xcvr_top.sv
module bus_xcvr_top
  import bus_xcvr_pkg::*;
#(
  parameter int unsigned LANE_W = LANE_W_DEF,
  parameter int unsigned LANES  = LANES_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*LANE_W-1:0] a_in,
  input  logic [LANES*LANE_W-1:0] b_in,
  input  logic                    ab_oe_n,
  input  logic                    ab_le,
  input  logic                    ab_ck,
  input  logic                    ba_oe_n,
  input  logic                    ba_le,
  input  logic                    ba_ck,
  input  logic                    tst_sel,
  input  logic [LANES*LANE_W-1:0] tst_b_data,
  input  logic [LANES*LANE_W-1:0] tst_a_data,
  input  logic                    tst_b_drive,
  input  logic                    tst_a_drive,
  output logic [LANES*LANE_W-1:0] b_out,
  output logic                    b_drive,
  output logic [LANES*LANE_W-1:0] a_out,
  output logic                    a_drive
);
  localparam int unsigned W = LANES * LANE_W;

  logic         rst_n_i;
  path_ctl_t    ab_ctl, ba_ctl;
  logic [W-1:0] ab_q, ba_q;
  logic         ab_drv, ba_drv;

  bus_xcvr_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_i)
  );

  always_comb begin
    ab_ctl = '{oe_n: ab_oe_n, le: ab_le, ck: ab_ck};
    ba_ctl = '{oe_n: ba_oe_n, le: ba_le, ck: ba_ck};
  end

  bus_xcvr_path #(.LANE_W(LANE_W), .LANES(LANES)) u_ab (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .ctl_in (ab_ctl),
    .d_in   (a_in),
    .d_out  (ab_q),
    .drive  (ab_drv)
  );

  bus_xcvr_path #(.LANE_W(LANE_W), .LANES(LANES)) u_ba (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .ctl_in (ba_ctl),
    .d_in   (b_in),
    .d_out  (ba_q),
    .drive  (ba_drv)
  );

  always_comb begin
    if (tst_sel) begin
      b_out   = tst_b_data;
      b_drive = tst_b_drive;
      a_out   = tst_a_data;
      a_drive = tst_a_drive;
    end else begin
      b_out   = ab_q;
      b_drive = ab_drv;
      a_out   = ba_q;
      a_drive = ba_drv;
    end
  end

  assert_ab_drive_R5: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!tst_sel && $past(rst_n_i)) |-> (b_drive == !$past(ab_oe_n)))
    else $error("B drive does not follow sampled enable");

  assert_ba_drive_R6: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!tst_sel && $past(rst_n_i)) |-> (a_drive == !$past(ba_oe_n)))
    else $error("A drive does not follow sampled enable");
endmodule

// File: tb/bus_xcvr_top_test.sv
`timescale 1ns/1ps
module bus_xcvr_top_test;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] in_d [2];
  logic in_oe [2], in_le [2], in_ck [2];
  logic tsel;
  logic [W-1:0] fd [2];
  logic fen [2];
  logic [W-1:0] b_out, a_out;
  logic b_drive, a_drive;

  int checks = 0;
  int failures = 0;
  int wd = 0;
  bit model_on = 0;

  logic m_le [2], m_ck [2], m_cp [2], m_oe [2], m_pr [2];
  logic [W-1:0] m_d [2], m_st [2];

  always #4 clk = ~clk;

  bus_xcvr_top uut (
    .clk(clk), .rst_n(rst_n),
    .a_in(in_d[0]), .b_in(in_d[1]),
    .ab_oe_n(in_oe[0]), .ab_le(in_le[0]), .ab_ck(in_ck[0]),
    .ba_oe_n(in_oe[1]), .ba_le(in_le[1]), .ba_ck(in_ck[1]),
    .tst_sel(tsel), .tst_b_data(fd[0]), .tst_a_data(fd[1]),
    .tst_b_drive(fen[0]), .tst_a_drive(fen[1]),
    .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_le[i] = 0; m_ck[i] = 0; m_cp[i] = 0; m_oe[i] = 1;
      m_pr[i] = 0; m_d[i] = '0; m_st[i] = '0;
    end
  endtask

  task automatic model_edge();
    for (int i = 0; i < 2; i++) begin
      if (m_le[i] || (m_pr[i] && m_ck[i] && !m_cp[i])) m_st[i] = m_d[i];
      m_cp[i] = m_pr[i] ? m_ck[i] : in_ck[i];
      m_ck[i] = in_ck[i];
      m_le[i] = in_le[i];
      m_oe[i] = in_oe[i];
      m_d[i]  = in_d[i];
      m_pr[i] = 1;
    end
  endtask

  function automatic logic [W-1:0] exp_data(int i);
    if (tsel) return fd[i];
    return m_le[i] ? m_d[i] : m_st[i];
  endfunction

  function automatic logic exp_drive(int i);
    if (tsel) return fen[i];
    return !m_oe[i];
  endfunction

  task automatic check_val(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_model(string tag_ab, string tag_ba);
    check_val(tag_ab, b_out, exp_data(0));
    check_val(tag_ab, {17'd0, b_drive}, {17'd0, exp_drive(0)});
    check_val(tag_ba, a_out, exp_data(1));
    check_val(tag_ba, {17'd0, a_drive}, {17'd0, exp_drive(1)});
  endtask

  task automatic cycle();
    @(posedge clk);
    if (model_on) model_edge();
    @(negedge clk);
  endtask

  function automatic string tag_for(int i);
    if (tsel) return "R7";
    if (m_le[i]) return "R1";
    return (i == 0) ? "R3" : "R6";
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    rst_n = 0;
    tsel = 0;
    for (int i = 0; i < 2; i++) begin
      in_d[i] = 18'h2AAAA; in_oe[i] = 0; in_le[i] = 0; in_ck[i] = 1;
      fd[i] = '0; fen[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R9: reset state
    check_val("R9 reset b_out", b_out, '0);
    check_val("R9 reset b_drive", {17'd0, b_drive}, '0);
    check_val("R9 reset a_out", a_out, '0);
    rst_n = 1;
    repeat (2) begin @(posedge clk); end
    @(negedge clk);
    model_on = 1;
    // clock held high across release: no capture
    repeat (3) cycle();
    check_val("R9 no false edge", b_out, '0);
    check_val("R5 drive after enable", {17'd0, b_drive}, 18'd1);
    check_model("R9", "R9");

    // R1 transparent
    in_le[0] = 1; in_d[0] = 18'h12345; in_ck[0] = 0;
    cycle();
    check_val("R1 transparent", b_out, 18'h12345);
    // R2 latch close
    in_le[0] = 0; in_d[0] = 18'h3FFFF;
    cycle();
    check_val("R2 close keeps last", b_out, 18'h12345);
    cycle();
    check_val("R3 hold clock low", b_out, 18'h12345);
    // R4 capture
    in_ck[0] = 1; in_d[0] = 18'h0F0F0;
    cycle();
    check_val("R4 not yet visible", b_out, 18'h12345);
    in_d[0] = 18'h11111;
    cycle();
    check_val("R4 captured", b_out, 18'h0F0F0);
    cycle();
    check_val("R3 hold clock high", b_out, 18'h0F0F0);
    // R5 disable
    in_oe[0] = 1;
    cycle();
    check_val("R5 drive off", {17'd0, b_drive}, '0);
    // R6 B to A path
    in_le[1] = 1; in_oe[1] = 0; in_d[1] = 18'h2468A;
    cycle();
    check_val("R6 transparent", a_out, 18'h2468A);
    check_val("R6 drive", {17'd0, a_drive}, 18'd1);
    check_val("R6 independent", b_out, 18'h0F0F0);
    // R7 override immediate
    tsel = 1; fd[0] = 18'h00F0F; fd[1] = 18'h15555; fen[0] = 1; fen[1] = 0;
    #1;
    check_val("R7 forced b", b_out, 18'h00F0F);
    check_val("R7 forced a", a_out, 18'h15555);
    check_val("R7 forced a drive", {17'd0, a_drive}, '0);
    // R8 capture during override
    in_ck[0] = 0; cycle();
    in_ck[0] = 1; in_d[0] = 18'h0ABCD; cycle();
    in_ck[0] = 1; cycle();
    check_val("R7 still forced", b_out, 18'h00F0F);
    tsel = 0;
    #1;
    check_val("R8 state kept", b_out, 18'h0ABCD);
    check_model("R8", "R8");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < 2; i++) begin
        in_d[i] = 18'($urandom);
        in_le[i] = ($urandom % 4) == 0;
        if (($urandom % 3) == 0) in_ck[i] = ~in_ck[i];
        in_oe[i] = ($urandom % 5) == 0;
        fd[i] = 18'($urandom);
        fen[i] = 1'($urandom);
      end
      tsel = ($urandom % 10) == 0;
      cycle();
      check_model(tag_for(0), tag_for(1));
    end
    summary();
  end
endmodule